// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one read or write transfer at a time on a bus whose lower lines carry first an address and then data. A requester offers a transfer when the sequencer is idle: a 20-bit address, 16-bit write data, a direction, a memory-or-I/O flag and a byte-or-word size. The sequencer then steps through four bus states, T1 to T4, and inserts wait states between T3 and T4 for as long as the addressed device holds its ready input low.

Each bus state lasts two clock cycles, a first half and a second half. This gives the sub-state timing the bus needs. The address latch enable pulses in the first half of T1, so external latches can capture the address on its falling edge. The read strobe waits until the second half of T2 so the bus has time to float. Write data stays on the bus until the middle of T4. Read data is sampled on the edge where the device is found ready. It is returned with a one-clock done pulse in the first half of T4.

Top module: `bus_seq_top`

## Requirements
- R1: While reset is held and right after it: ale_o=0, rd_n_o=1, wr_n_o=1, den_n_o=1, bus_oe_o=0, done_o=0, m_io_o=0, dt_r_o=0, bhe_n_o=1 and req_ready_o=1.
- R2: A request is taken only on a clock edge where req_ready_o=1 and req_valid_i=1. Its fields are held for the whole transfer. req_valid_i asserted while busy has no effect on the running transfer, and no second transfer is started after it.
- R3: T1 spans the first two clocks after acceptance. bus_oe_o=1 and bus_o carries the address in both clocks. ale_o=1 in the first clock only. For a word request, address bit 0 is driven as 0.
- R4: From T1 through T4, m_io_o equals the memory flag (1 = memory, 0 = I/O) and dt_r_o equals the direction (1 = write, 0 = read). Both stay constant for the whole transfer.
- R5: From T1 through T4, bhe_n_o and bus_o bit 0 (as driven in T1) select the bytes. A word gives bhe_n_o=0 with bit 0 = 0. A byte at an even address gives bhe_n_o=1 with bit 0 = 0. A byte at an odd address gives bhe_n_o=0 with bit 0 = 1.
- R6: On a read, bus_oe_o=0 from the start of T2 to the end of the transfer. rd_n_o=0 from the second half of T2 through the last clock of T3 or of the final wait state, and is 1 in T4.
- R7: On a write, bus_oe_o=1 from the start of T2 through the first half of T4, and bus_o holds the write data on bits 15:0 with bits 19:16 at 0. wr_n_o=0 from the start of T2 through the last clock of T3 or of the final wait state, and is 1 in T4.
- R8: ready_i is sampled only on the edge ending the second half of T3 and of each wait state. A low sample inserts one more wait state of two clocks.
- R9: Read data is taken from bus_i on the edge where ready_i is sampled high. It appears on rdata_o with done_o=1 for exactly the first half of T4, and rdata_o holds until the next capture.
- R10: den_n_o=0 exactly while a strobe is low and during the first half of T4; otherwise den_n_o=1.
- R11: While a strobe is active, {m_io_o, rd_n_o, wr_n_o} reads 001 for I/O read, 010 for I/O write, 101 for memory read and 110 for memory write. rd_n_o and wr_n_o are never low together.
- R12: A transfer with N wait states lasts 8+2N clocks. After it, req_ready_o=1 and all outputs return to their R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, two cycles per bus state |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request |
| req_ready_o | output | 1 | Sequencer idle, request may be taken |
| req_addr_i | input | 20 | Transfer address |
| req_wdata_i | input | 16 | Write data |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_mem_i | input | 1 | 1 = memory, 0 = I/O |
| req_word_i | input | 1 | 1 = word, 0 = byte |
| ready_i | input | 1 | Device ready, low inserts wait states |
| bus_i | input | 16 | Data returned on the shared lines |
| bus_o | output | 20 | Address in T1, write data later |
| bus_oe_o | output | 1 | Output enable for bus_o |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| m_io_o | output | 1 | 1 = memory, 0 = I/O |
| dt_r_o | output | 1 | Transceiver direction, 1 = transmit |
| den_n_o | output | 1 | Transceiver data enable, active low |
| bhe_n_o | output | 1 | High byte enable, active low |
| rdata_o | output | 16 | Captured read data |
| done_o | output | 1 | One-clock completion pulse |

## Verification
Every clock of every transfer is compared against a timeline built from the wait count. A read strobe that starts at the beginning of T2 shows up as rd_n_o low while the bus is still being released. A write that releases its data at the end of the strobe instead of mid-T4 shows up in the first half of T4. Read data is presented on bus_i only in the clock just before the capturing edge, so a design that samples one edge early or late returns the complement value. Odd byte addresses, word requests at odd addresses and a request raised in the middle of a transfer expose lane-decode errors, a missing bit-0 clear and a restart while busy.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bstate_e;

  // active-low high byte enable from size and address bit 0
  function automatic logic hi_lane_n(input logic word, input logic a0);
    return !(word || a0);
  endfunction
endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_valid_i,
  input  logic    ready_i,
  output bstate_e state_o,
  output logic    half_o,
  output logic    accept_o,
  output logic    capture_o
);
  bstate_e state_q, state_d;
  logic    half_q, half_d;
  logic    wait_pt;

  assign wait_pt   = (state_q == ST_T3 || state_q == ST_TW) && half_q;
  assign accept_o  = (state_q == ST_IDLE) && req_valid_i;
  assign capture_o = wait_pt && ready_i;

  always_comb begin
    state_d = state_q;
    half_d  = half_q;
    if (state_q == ST_IDLE) begin
      half_d = 1'b0;
      if (req_valid_i) state_d = ST_T1;
    end else if (!half_q) begin
      half_d = 1'b1;
    end else begin
      half_d = 1'b0;
      unique case (state_q)
        ST_T1:        state_d = ST_T2;
        ST_T2:        state_d = ST_T3;
        ST_T3, ST_TW: state_d = ready_i ? ST_T4 : ST_TW;
        ST_T4:        state_d = ST_IDLE;
        default:      state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      half_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      half_q  <= half_d;
    end
  end

  assign state_o = state_q;
  assign half_o  = half_q;

  AST_WAIT_ON_LOW_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_pt && !ready_i) |=> (state_q == ST_TW && !half_q)); // R8
  AST_T4_ON_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_pt && ready_i) |=> (state_q == ST_T4 && !half_q)); // R8
  AST_HALF_PAIRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !half_q) |=> (half_q && $stable(state_q))); // R12
endmodule

// File: rtl/bus_seq_ctl.sv
module bus_seq_ctl
  import bus_seq_pkg::*;
(
  input  bstate_e state_i,
  input  logic    half_i,
  input  logic    write_i,
  input  logic    mem_i,
  input  logic    word_i,
  input  logic    a0_i,
  output logic    ale_o,
  output logic    rd_n_o,
  output logic    wr_n_o,
  output logic    den_n_o,
  output logic    dt_r_o,
  output logic    m_io_o,
  output logic    bhe_n_o,
  output logic    bus_oe_o,
  output logic    done_o,
  output logic    idle_o
);
  logic active, data_ph, t4_first, t2_first, rd_act, wr_act;

  always_comb begin
    active   = (state_i != ST_IDLE);
    data_ph  = (state_i == ST_T2) || (state_i == ST_T3) || (state_i == ST_TW);
    t2_first = (state_i == ST_T2) && !half_i;
    t4_first = (state_i == ST_T4) && !half_i;
    // read strobe held back for the first half of T2 while the bus floats
    rd_act   = !write_i && data_ph && !t2_first;
    wr_act   = write_i && data_ph;

    ale_o    = (state_i == ST_T1) && !half_i;
    rd_n_o   = !rd_act;
    wr_n_o   = !wr_act;
    den_n_o  = !(rd_act || wr_act || t4_first);
    bus_oe_o = (state_i == ST_T1) || (write_i && (data_ph || t4_first));
    dt_r_o   = active && write_i;
    m_io_o   = active && mem_i;
    bhe_n_o  = active ? hi_lane_n(word_i, a0_i) : 1'b1;
    done_o   = t4_first;
    idle_o   = !active;
  end
endmodule

// File: rtl/bus_seq_dp.sv
module bus_seq_dp
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              req_write_i,
  input  logic              req_mem_i,
  input  logic              req_word_i,
  input  bstate_e           state_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [ADDR_W-1:0] bus_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              write_o,
  output logic              mem_o,
  output logic              word_o,
  output logic              a0_o
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              write_q, mem_q, word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      mem_q   <= 1'b0;
      word_q  <= 1'b0;
    end else if (accept_i) begin
      addr_q  <= {req_addr_i[ADDR_W-1:1], req_addr_i[0] & ~req_word_i};
      wdata_q <= req_wdata_i;
      write_q <= req_write_i;
      mem_q   <= req_mem_i;
      word_q  <= req_word_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= bus_i;
  end

  generate
    if (HI_W > 0) begin : g_hi
      assign bus_o = (state_i == ST_T1) ? addr_q : {{HI_W{1'b0}}, wdata_q};
    end else begin : g_flat
      assign bus_o = (state_i == ST_T1) ? addr_q : wdata_q[ADDR_W-1:0];
    end
  endgenerate

  assign rdata_o = rdata_q;
  assign write_o = write_q;
  assign mem_o   = mem_q;
  assign word_o  = word_q;
  assign a0_o    = addr_q[0];

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_IDLE) |=> ($stable(addr_q) && $stable(wdata_q) && $stable(write_q))); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(rdata_o)); // R9
endmodule

// File: rtl/bus_seq_top.sv
module bus_seq_top
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              req_write_i,
  input  logic              req_mem_i,
  input  logic              req_word_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [ADDR_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              m_io_o,
  output logic              dt_r_o,
  output logic              den_n_o,
  output logic              bhe_n_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  bstate_e state;
  logic    half, accept, capture;
  logic    write_q, mem_q, word_q, a0_q;

  bus_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .ready_i     (ready_i),
    .state_o     (state),
    .half_o      (half),
    .accept_o    (accept),
    .capture_o   (capture)
  );

  bus_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .capture_i   (capture),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_write_i (req_write_i),
    .req_mem_i   (req_mem_i),
    .req_word_i  (req_word_i),
    .state_i     (state),
    .bus_i       (bus_i),
    .bus_o       (bus_o),
    .rdata_o     (rdata_o),
    .write_o     (write_q),
    .mem_o       (mem_q),
    .word_o      (word_q),
    .a0_o        (a0_q)
  );

  bus_seq_ctl u_ctl (
    .state_i  (state),
    .half_i   (half),
    .write_i  (write_q),
    .mem_i    (mem_q),
    .word_i   (word_q),
    .a0_i     (a0_q),
    .ale_o    (ale_o),
    .rd_n_o   (rd_n_o),
    .wr_n_o   (wr_n_o),
    .den_n_o  (den_n_o),
    .dt_r_o   (dt_r_o),
    .m_io_o   (m_io_o),
    .bhe_n_o  (bhe_n_o),
    .bus_oe_o (bus_oe_o),
    .done_o   (done_o),
    .idle_o   (req_ready_o)
  );

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o)); // R11
  AST_READ_FLOATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> !bus_oe_o); // R6
  AST_ALE_FALL_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> (bus_oe_o && $stable(bus_o))); // R3
  AST_MIO_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && $past(!req_ready_o)) |-> ($stable(m_io_o) && $stable(dt_r_o))); // R4
  AST_DEN_COVERS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !wr_n_o) |-> !den_n_o); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && req_valid_i) |=> !ale_o); // R2
endmodule

// File: tb/tb_bus_seq_top.sv
`timescale 1ns/1ps
module tb_bus_seq_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [19:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        req_write_i = 1'b0, req_mem_i = 1'b0, req_word_i = 1'b0;
  logic        ready_i = 1'b0;
  logic [15:0] bus_i = '0;
  logic [19:0] bus_o;
  logic        bus_oe_o, ale_o, rd_n_o, wr_n_o, m_io_o, dt_r_o, den_n_o, bhe_n_o, done_o;
  logic [15:0] rdata_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  bus_seq_top dut (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, "ale", ale_o, 0);           chk(req, "rd_n", rd_n_o, 1);
    chk(req, "wr_n", wr_n_o, 1);         chk(req, "den_n", den_n_o, 1);
    chk(req, "oe", bus_oe_o, 0);         chk(req, "done", done_o, 0);
    chk(req, "m_io", m_io_o, 0);         chk(req, "dt_r", dt_r_o, 0);
    chk(req, "bhe_n", bhe_n_o, 1);       chk(req, "req_ready", req_ready_o, 1);
  endtask

  // one full transfer, checked clock by clock
  task automatic run_cycle(input logic [19:0] addr, input logic [15:0] wd, input logic wr,
                           input logic mem, input logic word, input int nw,
                           input logic [15:0] rv, input bit poke);
    int last_w = 5 + 2*nw;
    int t4a    = 6 + 2*nw;
    int total  = 8 + 2*nw;
    logic [19:0] aexp = word ? {addr[19:1], 1'b0} : addr;
    logic bexp = !(word || addr[0]);
    @(negedge clk_i);
    chk("R2", "ready before req", req_ready_o, 1);
    req_addr_i = addr; req_wdata_i = wd; req_write_i = wr; req_mem_i = mem; req_word_i = word;
    req_valid_i = 1'b1;
    for (int i = 0; i < total; i++) begin
      logic strobe;
      @(posedge clk_i);
      @(negedge clk_i);
      req_valid_i = 1'b0;
      strobe = wr ? (i >= 2 && i <= last_w) : (i >= 3 && i <= last_w);
      chk("R3", "ale", ale_o, i == 0);
      chk("R2", "req_ready", req_ready_o, 0);
      chk("R4", "m_io", m_io_o, mem);
      chk("R4", "dt_r", dt_r_o, wr);
      chk("R5", "bhe_n", bhe_n_o, bexp);
      chk("R10", "den_n", den_n_o, !(strobe || i == t4a));
      chk("R9", "done", done_o, i == t4a);
      if (i < 2) begin
        chk("R3", "oe T1", bus_oe_o, 1);
        chk("R3", "addr", bus_o, aexp);
        chk("R5", "a0", bus_o[0], !word && addr[0]);
      end else if (wr) begin
        chk("R7", "oe write", bus_oe_o, i <= t4a);
        if (i <= t4a) chk("R7", "wdata", bus_o, {4'h0, wd});
      end else begin
        chk("R6", "oe read", bus_oe_o, 0);
      end
      chk(wr ? "R7" : "R6", "rd_n", rd_n_o, !(!wr && strobe));
      chk(wr ? "R7" : "R6", "wr_n", wr_n_o, !(wr && strobe));
      if (strobe) chk("R11", "type", {m_io_o, rd_n_o, wr_n_o}, {mem, wr, !wr});
      if (!wr && i == t4a) chk("R9", "rdata", rdata_o, rv);
      // drive device for the coming edge
      ready_i = (i == last_w);
      bus_i   = (i == last_w) ? rv : ~rv;
      if (poke && i == 3) begin
        req_valid_i = 1'b1; req_addr_i = 20'hFFFFF; req_write_i = ~wr; req_word_i = ~word;
      end
    end
    ready_i = 1'b0;
    req_valid_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    chk_idle("R12");
    if (!wr) chk("R9", "rdata hold", rdata_o, rv);
  endtask

  task automatic t_reset();
    #1;
    chk_idle("R1");
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1");
  endtask

  task automatic t_mem_word_read();    run_cycle(20'h155A4, 16'h0, 0, 1, 1, 0, 16'hBEEF, 0); endtask
  task automatic t_io_byte_read_odd(); run_cycle(20'h00043, 16'h0, 0, 0, 0, 2, 16'h5A3C, 0); endtask
  task automatic t_mem_byte_write();   run_cycle(20'hA0010, 16'h00C7, 1, 1, 0, 1, 16'h0, 0); endtask
  task automatic t_io_word_write_odd_poke(); run_cycle(20'h00301, 16'h1234, 1, 0, 1, 0, 16'h0, 1); endtask
  task automatic t_read_long_wait_poke();    run_cycle(20'hFFFFE, 16'h0, 0, 1, 1, 3, 16'h0F0F, 1); endtask
  task automatic t_mem_byte_write_odd();     run_cycle(20'h12345, 16'hAB00, 1, 1, 0, 0, 16'h0, 0); endtask

  task automatic t_ignore_busy_no_restart();
    // R2: after a poked transfer, no second one starts
    run_cycle(20'h00100, 16'h0, 0, 0, 1, 0, 16'h7777, 1);
    repeat (3) begin
      @(posedge clk_i);
      @(negedge clk_i);
      chk("R2", "no restart ale", ale_o, 0);
      chk("R2", "no restart ready", req_ready_o, 1);
    end
  endtask

  initial begin
    t_reset();
    t_mem_word_read();
    t_io_byte_read_odd();
    t_mem_byte_write();
    t_io_word_write_odd_poke();
    t_read_long_wait_poke();
    t_mem_byte_write_odd();
    t_ignore_busy_no_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule